// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block moves data, one unit per request, from a source address to a destination address over a simple synchronous memory bus. Software programs a start source, a start destination, a transfer count and a control word through a small register port. After that the channel waits. Each request, from a hardware pulse or from a software bit, causes one read cycle and then one write cycle.

Each address can step forward after every unit or stay put. With a fixed destination, for example an output port, and a cyclic source buffer, repeat mode gives an endless waveform that needs no processor time. That is how a timer tick can drive a pulse-width pattern onto a port. In single mode the channel stops after the programmed count and raises a one-cycle completion pulse.

Top module: `dma1_channel`

## Requirements
- R1: Register offsets: 0 = start source, 1 = start destination, 2 = transfer count, 3 = control. Writes to offsets 0 to 2 set only the programmed (reload) values. When enable changes from 0 to 1, the working source, destination and count are loaded from them. Reads of offsets 0, 1 and 2 return the working source, working destination and remaining count, and offset 3 returns control bits 4..0. After reset every register reads 0.
- R2: When enable (control bit 0) is 0, hardware pulses and software requests are ignored, and no bus cycle occurs.
- R3: A request is a high `hw_req` sampled at a clock edge, or a write to offset 3 with bit 5 set. The bit-5 request counts when the channel is enabled after that write (the same write may set enable). Bit 5 reads back as 0.
- R4: Each request produces one read cycle (`mem_req`=1, `mem_we`=0, source address), followed in the next cycle by one write cycle (`mem_we`=1, destination address). The write data is the value read. Control bit 1 selects the size: 0 = byte (`mem_word`=0, only the low 8 bits are moved, upper write bits are 0), 1 = 16-bit word.
- R5: After each unit, the working source advances by 1 (byte) or 2 (word) when control bit 2 is set, and stays fixed otherwise. Control bit 3 does the same for the destination.
- R6: The remaining count drops by one per unit. A programmed count of 0 means 2^CW units.
- R7: With repeat (control bit 4 = 1), when the last unit completes, the working source, destination and count are reloaded from the programmed values and enable stays 1.
- R8: Without repeat, when the last unit completes, enable clears, any latched request is dropped, and `done_irq` is high for exactly one cycle.
- R9: A request that arrives while a transfer is in progress is latched and served after that transfer ends. Several such requests during one transfer merge into a single extra transfer.
- R10: A control write made during the read cycle of a transfer takes effect only when that transfer's write cycle ends. Until then, offset 3 reads the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data (combinational from `cfg_addr`) |
| hw_req | input | 1 | Hardware transfer request |
| mem_req | output | 1 | Bus cycle active |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_word | output | 1 | 1 = 16-bit unit, 0 = byte |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle after the read request |
| done_irq | output | 1 | One-cycle completion pulse in single mode |

## Verification
Assertions check on every cycle that:
- each read cycle is followed by exactly one write cycle;
- a disabled channel holds no latched request;
- addresses and the count step correctly after each non-final unit;
- repeat mode reloads the working values;
- the completion pulse lasts one cycle;
- the control word cannot change during a read cycle.

The data actually landing in memory, the merging of requests, the 2^CW meaning of a zero count, and the deferred disable can be shown only by bench scenarios. For those, the bench sweeps every combination of size and the two address-step modes and compares the whole memory image with an arithmetic model.

// File: rtl/dma1_pkg.sv
package dma1_pkg;
    localparam int DATA_W = 16;
    localparam int CTRL_W = 5;
    localparam int CB_SOFT = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } dma_st_e;

    // packed order gives bit 0 = enable ... bit 4 = repeat
    typedef struct packed {
        logic rpt;
        logic dinc;
        logic sinc;
        logic word;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/dma1_step.sv
module dma1_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic          inc,
    input  logic          word,
    output logic [AW-1:0] next
);
    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_W = AW'(2);

    always_comb begin
        if (!inc)
            next = addr;
        else
            next = addr + (word ? STEP_W : STEP_B);
    end
endmodule

// File: rtl/dma1_count.sv
module dma1_count #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] next,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        next = cnt - ONE;
        last = (cnt == ONE);
    end
endmodule

// File: rtl/dma1_channel.sv
module dma1_channel
    import dma1_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic              hw_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done_irq
);
    localparam int NPTR = 2;

    typedef struct packed {
        dma_st_e       st;
        logic [AW-1:0] src_rl;
        logic [AW-1:0] dst_rl;
        logic [CW-1:0] cnt_rl;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        ctrl_t         ctrl;
        logic          pend;
        logic          dfr_v;
        ctrl_t         dfr;
        logic          irq;
    } regs_t;

    regs_t q, d;

    logic [AW-1:0] cur_a [NPTR];
    logic [AW-1:0] nxt_a [NPTR];
    logic          inc_a [NPTR];
    logic [CW-1:0] cnt_nx;
    logic          cnt_last;

    assign cur_a[0] = q.src;
    assign cur_a[1] = q.dst;
    assign inc_a[0] = q.ctrl.sinc;
    assign inc_a[1] = q.ctrl.dinc;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dma1_step #(.AW(AW)) u_step (
            .addr (cur_a[g]),
            .inc  (inc_a[g]),
            .word (q.ctrl.word),
            .next (nxt_a[g])
        );
    end

    dma1_count #(.CW(CW)) u_cnt (
        .cnt  (q.cnt),
        .next (cnt_nx),
        .last (cnt_last)
    );

    function automatic regs_t apply_ctrl(regs_t r, ctrl_t c);
        regs_t o;
        o = r;
        if (c.en && !r.ctrl.en) begin
            o.src = r.src_rl;
            o.dst = r.dst_rl;
            o.cnt = r.cnt_rl;
        end
        if (!c.en)
            o.pend = 1'b0;
        o.ctrl = c;
        return o;
    endfunction

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (q.ctrl.en && (hw_req || q.pend)) begin
                    d.st   = ST_RD;
                    d.pend = 1'b0;
                end
            end
            ST_RD: begin
                d.st = ST_WR;
                if (hw_req && q.ctrl.en)
                    d.pend = 1'b1;
            end
            ST_WR: begin
                d.st = ST_IDLE;
                if (hw_req && q.ctrl.en)
                    d.pend = 1'b1;
                d.src = nxt_a[0];
                d.dst = nxt_a[1];
                d.cnt = cnt_nx;
                if (cnt_last) begin
                    if (q.ctrl.rpt) begin
                        d.src = q.src_rl;
                        d.dst = q.dst_rl;
                        d.cnt = q.cnt_rl;
                    end else begin
                        d.ctrl.en = 1'b0;
                        d.pend    = 1'b0;
                        d.irq     = 1'b1;
                    end
                end
                if (q.dfr_v) begin
                    d       = apply_ctrl(d, q.dfr);
                    d.dfr_v = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (cfg_we) begin
            unique case (cfg_addr)
                2'd0: d.src_rl = cfg_wdata;
                2'd1: d.dst_rl = cfg_wdata;
                2'd2: d.cnt_rl = cfg_wdata[CW-1:0];
                default: begin
                    if (q.st == ST_RD) begin
                        d.dfr_v = 1'b1;
                        d.dfr   = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                    end else begin
                        d = apply_ctrl(d, ctrl_t'(cfg_wdata[CTRL_W-1:0]));
                    end
                    if (cfg_wdata[CB_SOFT] && d.ctrl.en)
                        d.pend = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign mem_req   = (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_we    = (q.st == ST_WR);
    assign mem_word  = q.ctrl.word;
    assign mem_addr  = (q.st == ST_WR) ? q.dst : q.src;
    assign mem_wdata = q.ctrl.word ? mem_rdata : {8'h00, mem_rdata[7:0]};
    assign done_irq  = q.irq;

    always_comb begin
        unique case (cfg_addr)
            2'd0:    cfg_rdata = q.src;
            2'd1:    cfg_rdata = q.dst;
            2'd2:    cfg_rdata = AW'(q.cnt);
            default: cfg_rdata = AW'(q.ctrl);
        endcase
    end

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mem_req && mem_we)); // R4
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !mem_we); // R4
    AST_NO_PEND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl.en |-> !q.pend); // R2
    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR && !cnt_last && !cfg_we) |=>
        (q.src == $past(q.src) + AW'($past(q.ctrl.sinc) ? ($past(q.ctrl.word) ? 2 : 1) : 0))); // R5
    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR && !cnt_last && !cfg_we) |=>
        (q.dst == $past(q.dst) + AW'($past(q.ctrl.dinc) ? ($past(q.ctrl.word) ? 2 : 1) : 0))); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR && !cnt_last && !cfg_we) |=> (q.cnt == $past(q.cnt) - CW'(1))); // R6
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR && cnt_last && q.ctrl.rpt && q.ctrl.en && !cfg_we && !q.dfr_v) |=>
        (q.src == $past(q.src_rl) && q.dst == $past(q.dst_rl) &&
         q.cnt == $past(q.cnt_rl) && q.ctrl.en)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R8
    AST_DONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!q.ctrl.en || $past(cfg_we) || $past(q.dfr_v))); // R8
    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RD) |=> $stable(q.ctrl)); // R10
endmodule

// File: tb/dma1_channel_test.sv
`timescale 1ns/1ps
module dma1_channel_test;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          hw_req = 1'b0;
    logic          mem_req, mem_we, mem_word, done_irq;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;

    dma1_channel #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done_irq(done_irq)
    );

    always #2 clk = ~clk;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int n_chk = 0;
    int n_err = 0;
    int prot_err = 0;
    int irq_n = 0;
    int rd_n = 0;
    bit done_flag = 0;

    // memory model: read data valid in the cycle after the read request
    always @(posedge clk) begin
        if (mem_req) begin
            if (!mem_we)
                mem_rdata <= mem_word ? {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]}
                                      : {8'h00, mem[mem_addr[7:0]]};
            else begin
                mem[mem_addr[7:0]] <= mem_wdata[7:0];
                if (mem_word) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
            end
        end
    end

    // bus and interrupt monitor (R4, R8)
    logic        prev_rd = 1'b0;
    logic        prev_irq = 1'b0;
    logic [15:0] exp_wd = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rd && !(mem_req && mem_we && mem_wdata == exp_wd)) prot_err++;
            if (mem_req && !mem_we) begin
                rd_n++;
                exp_wd = mem_word ? {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]}
                                  : {8'h00, mem[mem_addr[7:0]]};
            end
            if (done_irq) irq_n++;
            if (done_irq && prev_irq) prot_err++;
            prev_rd  = mem_req && !mem_we;
            prev_irq = done_irq;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] a, output logic [AW-1:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        hw_req = 1'b1;
        @(negedge clk);
        hw_req = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    endtask

    task automatic model(input int src, input int dst, input bit word, input bit si,
                         input bit di, input int cnt, input int n);
        int step;
        step = word ? 2 : 1;
        for (int k = 0; k < n; k++) begin
            int s, t;
            logic [7:0] b0, b1;
            s = (src + (si ? (k % cnt) * step : 0)) & 255;
            t = (dst + (di ? (k % cnt) * step : 0)) & 255;
            b0 = exp_mem[s];
            b1 = exp_mem[(s + 1) & 255];
            exp_mem[t] = b0;
            if (word) exp_mem[(t + 1) & 255] = b1;
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== exp_mem[i]) bad++;
        chk(req, bad, 0);
    endtask

    initial begin
        logic [AW-1:0] v;
        int irq0, rd0;

        wait_cyc(4);
        chk("R1 reset mem_req", mem_req, 0);
        chk("R8 reset done_irq", done_irq, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            cfg_rd(2'(a), v);
            chk("R1 reset register", v, 0);
        end

        // sweep: size x source step x destination step, single mode, 3 units
        for (int m = 0; m < 8; m++) begin
            bit w, si, di;
            int step;
            w = m[0]; si = m[1]; di = m[2];
            step = w ? 2 : 1;
            fill_mem();
            cfg_wr(2'd0, 16'h0010);
            cfg_wr(2'd1, 16'h0080);
            cfg_wr(2'd2, 16'd3);
            irq0 = irq_n;
            cfg_wr(2'd3, AW'({1'b0, di, si, w, 1'b1}));
            for (int p = 0; p < 3; p++) begin
                pulse();
                wait_cyc(3);
            end
            model(16'h10, 16'h80, w, si, di, 3, 3);
            cmp_mem("R4 memory image after sweep transfers");
            chk("R8 one completion pulse", irq_n - irq0, 1);
            cfg_rd(2'd3, v);
            chk("R8 enable cleared", v[0], 0);
            cfg_rd(2'd0, v);
            chk("R5 source after 3 units", v, 16'h10 + (si ? 3 * step : 0));
            cfg_rd(2'd1, v);
            chk("R5 destination after 3 units", v, 16'h80 + (di ? 3 * step : 0));
            cfg_rd(2'd2, v);
            chk("R6 count exhausted", v, 0);
        end

        // R7 repeat: 4-unit cycle, 6 requests
        fill_mem();
        cfg_wr(2'd0, 16'h0020);
        cfg_wr(2'd1, 16'h00A0);
        cfg_wr(2'd2, 16'd4);
        irq0 = irq_n;
        cfg_wr(2'd3, 16'h001D);
        for (int p = 0; p < 6; p++) begin
            pulse();
            wait_cyc(3);
        end
        model(16'h20, 16'hA0, 0, 1, 1, 4, 6);
        cmp_mem("R7 memory image in repeat mode");
        cfg_rd(2'd0, v); chk("R7 source after wrap", v, 16'h22);
        cfg_rd(2'd1, v); chk("R7 destination after wrap", v, 16'hA2);
        cfg_rd(2'd2, v); chk("R7 count after wrap", v, 2);
        cfg_rd(2'd3, v); chk("R7 enable kept", v[0], 1);
        chk("R7 no completion pulse", irq_n - irq0, 0);

        // R2 disabled channel ignores requests
        cfg_wr(2'd3, 16'h0000);
        rd0 = rd_n;
        pulse();
        wait_cyc(4);
        chk("R2 no bus cycle while disabled", rd_n - rd0, 0);
        cfg_rd(2'd2, v); chk("R2 count untouched while disabled", v, 2);
        cfg_wr(2'd3, 16'h0020);
        wait_cyc(4);
        chk("R3 soft bit ignored while disabled", rd_n - rd0, 0);

        // R3 software request
        fill_mem();
        cfg_wr(2'd0, 16'h0030);
        cfg_wr(2'd1, 16'h0090);
        cfg_wr(2'd2, 16'd2);
        irq0 = irq_n;
        cfg_wr(2'd3, 16'h002D);
        wait_cyc(4);
        cfg_rd(2'd2, v); chk("R3 soft request moved one unit", v, 1);
        cfg_rd(2'd3, v); chk("R3 soft bit reads 0", v[5], 0);
        cfg_wr(2'd3, 16'h002D);
        wait_cyc(4);
        model(16'h30, 16'h90, 0, 1, 1, 2, 2);
        cmp_mem("R3 memory after soft requests");
        chk("R3 completion after soft requests", irq_n - irq0, 1);

        // R9 requests during a transfer merge into one more
        cfg_wr(2'd0, 16'h0040);
        cfg_wr(2'd1, 16'h00B0);
        cfg_wr(2'd2, 16'd5);
        cfg_wr(2'd3, 16'h000D);
        rd0 = rd_n;
        @(negedge clk); hw_req = 1'b1;
        wait_cyc(3);
        hw_req = 1'b0;
        wait_cyc(6);
        chk("R9 transfers from held request", rd_n - rd0, 2);
        cfg_rd(2'd2, v); chk("R9 count after merged requests", v, 3);

        // R10 control write during read cycle is deferred
        cfg_wr(2'd3, 16'h0000);
        cfg_wr(2'd3, 16'h000D);
        rd0 = rd_n;
        @(negedge clk); hw_req = 1'b1;
        @(negedge clk); hw_req = 1'b0;
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'h0000;
        @(negedge clk); cfg_we = 1'b0;
        #1 chk("R10 enable still set during transfer", cfg_rdata[0], 1);
        wait_cyc(3);
        cfg_rd(2'd3, v); chk("R10 disable applied after transfer", v[0], 0);
        cfg_rd(2'd2, v); chk("R10 started transfer completed", v, 4);
        chk("R10 exactly one transfer", rd_n - rd0, 1);

        // R6 programmed count 0 means 256 units
        fill_mem();
        cfg_wr(2'd0, 16'h0050);
        cfg_wr(2'd1, 16'h00C0);
        cfg_wr(2'd2, 16'd0);
        irq0 = irq_n;
        cfg_wr(2'd3, 16'h0001);
        for (int p = 0; p < 255; p++) begin
            pulse();
            wait_cyc(2);
        end
        wait_cyc(2);
        cfg_rd(2'd2, v); chk("R6 one unit left after 255", v, 1);
        cfg_rd(2'd3, v); chk("R6 still enabled after 255", v[0], 1);
        chk("R6 no early completion", irq_n - irq0, 0);
        pulse();
        wait_cyc(3);
        chk("R6 completion after 256 units", irq_n - irq0, 1);
        model(16'h50, 16'hC0, 0, 0, 0, 256, 256);
        cmp_mem("R6 fixed-address memory image");

        chk("R4 R8 bus pairing and pulse width monitor", prot_err, 0);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule